// File: doc/BRIEF.md
# Byte-at-a-time SPI host for serial flash commands

This block is an SPI host that a processor drives through a four-register bus to issue raw serial-flash commands one byte at a time. Software raises chip select, sets a packed configuration word (bit count, lane width and lane mask), then writes each command, address or data byte into the data register. It polls a status word for transmit and receive readiness, and reads back the byte that was shifted in. Chip select stays where software put it, so a command of any length is framed by two writes to the select register.

The serial side runs in single-lane SPI mode 0. The clock idles low, the host output changes on falling clock edges and the input is sampled on rising edges. Each half period of the serial clock lasts `DIV` system clocks. Bits go out most significant first.

Top module: `byte_spi_host`

## Requirements
- R1: After reset, the status word reads 0x1, the configuration word reads 0, `spi_cs_n` is high, and `spi_sclk` and `spi_mosi` are low.
- R2: The register word address selects the register: 0 is select control (bit 0), 1 is configuration, 2 is data and 3 is status. The configuration word holds bit count in [7:0], lane width in [15:8] and lane mask in [23:16]. It reads back as written, with bits [31:24] reading zero.
- R3: Writing 1 to bit 0 of the select register drives `spi_cs_n` low in the next cycle. Writing 0 drives it high. It does not change between the bytes of a multi-byte command.
- R4: Status bit 0 (transmit ready) is low while a byte is in flight and high otherwise. Status bit 1 (receive ready) goes high when a byte completes.
- R5: With bit count 8 and lane mask bit 0 set, a data write sends the byte most significant bit first on `spi_mosi` over exactly 8 rising clock edges. A later data read returns the 8 `spi_miso` bits, the first-received bit in bit 7.
- R6: Mode 0 timing holds. `spi_sclk` is low when idle, and `spi_mosi` changes only while the clock is low. `spi_miso` is sampled at the rising edge. Each clock half period lasts `DIV` system clocks.
- R7: With bit count 0, a data write is ignored. No clock edge appears, and the status word stays 0x1.
- R8: A data write while transmit ready is low is ignored. The byte in flight keeps its bits and its edge count.
- R9: Reading the data register clears receive ready.
- R10: A bit count from 1 to 7 shifts only that many bits, taken from the top of the written byte. The received bits land in the low bits of the data register. A count above 8 acts as 8.
- R11: With lane mask bit 0 clear, `spi_mosi` stays low while the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that every register access lasts a single cycle of `bus_sel`. They also assume that `spi_miso` changes only after a rising serial clock edge. The bench's flash model moves its output bit just after each rising edge it observes. The bench bus tasks drive one-cycle strobes at the falling system clock edge. Mid-transfer writes are placed only where the requirement for ignored writes calls for them.

// File: rtl/byte_spi_host.sv
`timescale 1ns/1ps
module byte_spi_host #(
  parameter int unsigned DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int unsigned DIVW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [1:0] A_SEL = 2'd0, A_CFG = 2'd1, A_DAT = 2'd2, A_STS = 2'd3;

  logic            sel_q, busy, rx_rdy, sclk_q, msk_q;
  logic [23:0]     cfg_q;
  logic [7:0]      sh_q, cap_q, rx_q;
  logic [3:0]      bits_q, nb_q;
  logic [DIVW-1:0] div_q;

  wire       wr    = bus_sel & bus_we;
  wire       rd    = bus_sel & ~bus_we;
  wire [7:0] len   = cfg_q[7:0];
  wire [3:0] nbits = (len > 8'd8) ? 4'd8 : len[3:0];
  wire       start = wr && bus_addr == A_DAT && !busy && len != 8'd0;
  wire       tick  = div_q == DIVW'(DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      cfg_q  <= '0;
      busy   <= 1'b0;
      rx_rdy <= 1'b0;
      sclk_q <= 1'b0;
      msk_q  <= 1'b0;
      sh_q   <= '0;
      cap_q  <= '0;
      rx_q   <= '0;
      bits_q <= '0;
      nb_q   <= '0;
      div_q  <= '0;
    end else begin
      if (wr && bus_addr == A_SEL) sel_q <= bus_wdata[0];
      if (wr && bus_addr == A_CFG) cfg_q <= bus_wdata[23:0];
      if (rd && bus_addr == A_DAT) rx_rdy <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        sh_q   <= bus_wdata[7:0];
        cap_q  <= '0;
        bits_q <= '0;
        nb_q   <= nbits;
        msk_q  <= cfg_q[16];
        div_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            cap_q <= {cap_q[6:0], spi_miso};
          end else begin
            sh_q   <= {sh_q[6:0], 1'b0};
            bits_q <= bits_q + 4'd1;
            if (bits_q == nb_q - 4'd1) begin
              busy   <= 1'b0;
              rx_q   <= cap_q;
              rx_rdy <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + DIVW'(1);
        end
      end
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = ~sel_q;
  assign spi_mosi = busy & msk_q & sh_q[7];

  always_comb begin
    case (bus_addr)
      A_SEL:   bus_rdata = {31'b0, sel_q};
      A_CFG:   bus_rdata = {8'b0, cfg_q};
      A_DAT:   bus_rdata = {24'b0, rx_q};
      default: bus_rdata = {30'b0, rx_rdy, ~busy};
    endcase
  end
endmodule

// File: rtl/byte_spi_host_chk.sv
`timescale 1ns/1ps
module byte_spi_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        busy,
  input logic        rx_rdy,
  input logic [23:0] cfg_q
);
  // R3
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd0) |=> (spi_cs_n == !$past(bus_wdata[0])));
  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R4
  edge_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> busy);
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7:0] == 8'd0 && !busy) |=> !busy);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd2 && !busy) |=> !rx_rdy);
endmodule

bind byte_spi_host byte_spi_host_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .busy(busy), .rx_rdy(rx_rdy),
  .cfg_q(cfg_q)
);

// File: tb/byte_spi_host_tb_top.sv
`timescale 1ns/1ps
module byte_spi_host_tb_top;
  localparam int DIV = 2;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  byte_spi_host #(.DIV(DIV)) dut_i (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] reply_byte = 0;
  int ridx = 0;
  assign spi_miso = (ridx < 8) ? reply_byte[3'(7 - ridx)] : 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] mon_sh = 0;
  int mon_n = 0, mon_len = 8, edges = 0, cs_rise = 0, mosi_hi = 0;
  realtime t_prev = 0, period = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge spi_sclk) begin
    ridx <= ridx + 1;
    edges++;
    period = $realtime - t_prev;
    t_prev = $realtime;
    mon_sh = {mon_sh[6:0], spi_mosi};
    mon_n++;
    if (mon_n == mon_len) begin
      logic [7:0] e, m;
      m = mon_sh & 8'((1 << mon_len) - 1);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk(m == e, "R5 mosi bits", m, e);
      mon_n = 0;
    end
  end
  always @(posedge spi_cs_n) cs_rise++;
  always @(posedge clk) if (spi_mosi) mosi_hi++;

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      bread(2'd3, s);
      if (s[1]) break;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rep, input int nb,
                      input logic [7:0] exp_rx, input logic [7:0] exp_mosi, input string tag);
    logic [31:0] d;
    reply_byte = rep; ridx = 0; edges = 0; mon_n = 0; mon_len = nb;
    exp_q.push_back(exp_mosi);
    bwrite(2'd2, {24'b0, tx});
    wait_rx();
    bread(2'd2, d);
    chk(d[7:0] == exp_rx, tag, d[7:0], exp_rx);
    chk(edges == nb, "R5/R10 edge count", edges, nb);
  endtask

  initial begin
    logic [31:0] d;
    #3 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bread(2'd3, d); chk(d == 32'h1, "R1 status", d, 1);
    bread(2'd1, d); chk(d == 0, "R1 config", d, 0);
    chk(spi_cs_n && !spi_sclk && !spi_mosi, "R1 pins", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);

    bwrite(2'd0, 1);
    chk(!spi_cs_n, "R3 cs low", spi_cs_n, 0);
    edges = 0;
    bwrite(2'd2, 32'hA5);
    repeat (20) @(negedge clk);
    chk(edges == 0, "R7 no clock", edges, 0);
    bread(2'd3, d); chk(d == 32'h1, "R7 status", d, 1);

    bwrite(2'd1, 32'hFF010108);
    bread(2'd1, d); chk(d == 32'h00010108, "R2 config", d, 32'h00010108);

    cs_rise = 0;
    xfer(8'h9F, 8'hC2, 8, 8'hC2, 8'h9F, "R5 rx byte 9F/C2");
    chk(period == 2.0 * DIV * 5.0, "R6 period", int'(period), 2 * DIV * 5);
    xfer(8'h01, 8'h80, 8, 8'h80, 8'h01, "R5 rx byte 01/80");
    xfer(8'hFE, 8'h3C, 8, 8'h3C, 8'hFE, "R5 rx byte FE/3C");
    chk(cs_rise == 0 && !spi_cs_n, "R3 cs held", cs_rise, 0);

    reply_byte = 8'h5A; ridx = 0; edges = 0; mon_n = 0; mon_len = 8;
    exp_q.push_back(8'hC3);
    bwrite(2'd2, 32'hC3);
    bread(2'd3, d); chk(d[0] == 0, "R4 tx ready low", d[0], 0);
    bwrite(2'd2, 32'h00);
    wait_rx();
    bread(2'd3, d); chk(d[1:0] == 2'b11, "R4 ready flags", d[1:0], 3);
    bread(2'd2, d); chk(d[7:0] == 8'h5A, "R8 rx kept", d[7:0], 8'h5A);
    chk(edges == 8, "R8 edges", edges, 8);
    bread(2'd3, d); chk(d[1] == 0, "R9 rx cleared", d[1], 0);

    bwrite(2'd1, 32'h00010104);
    xfer(8'hB7, 8'hD0, 4, 8'h0D, 8'h0B, "R10 len4 rx");
    bwrite(2'd1, 32'h00010120);
    xfer(8'h66, 8'h99, 8, 8'h99, 8'h66, "R10 len>8 rx");

    bwrite(2'd1, 32'h00000108);
    mosi_hi = 0;
    xfer(8'hFF, 8'h12, 8, 8'h12, 8'h00, "R11 rx");
    chk(mosi_hi == 0, "R11 mosi low", mosi_hi, 0);

    bwrite(2'd0, 0);
    chk(spi_cs_n, "R3 cs high", spi_cs_n, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule